// File: doc/BRIEF.md
# Synthesizer Profile Write-Stream Packer

This block turns one profile update for a multi-channel frequency synthesizer into a packed stream of register-write records and hands it out as 32-bit words. A start strobe captures a four-bit channel mask, the two-bit serial-mode code and up to three optional settings: a frequency word, a phase word and an amplitude-control word, each with its own valid flag. The block then writes records into a 16-byte buffer. Each record is an address byte followed by big-endian data bytes, with no gap between records. The first record always selects the target channels. The optional records follow in a fixed order.

The stream is brought to a 4-byte boundary with dummy register writes, not zero fill, so every byte the receiver sees still belongs to a legal write. The finished words go out over a ready/valid port, together with the number of words in the stream.

The controller has three states. IDLE waits for `start` (transition IDLE→PACK). PACK registers the assembled buffer and the word count (transition PACK→SEND, always taken). SEND offers one word per handshake. It stays in SEND while words remain and returns to IDLE when the last word is accepted (transition SEND→IDLE).

Top module: `psp_stream_packer`

## Requirements
- R1: After reset, `busy` and `word_valid` are 0.
- R2: Stream bytes 0 and 1 are always address 0x00, then a channel-select byte. That byte holds `chan_mask[n]` on bit 4+n and `mode_code` on bits 2:1. Bits 3 and 0 are 0.
- R3: The optional records follow with no gaps, each present only when its flag is set. The order is: frequency (0x04, then `freq_word` as 4 bytes MSB first), phase (0x05, then `phase_word` as 2 bytes MSB first), amplitude (0x06, then `ampl_word[23:0]` as 3 bytes MSB first).
- R4: If the records end 2 bytes short of a multiple of 4, the pad is 0x00 followed by a byte with `mode_code` on bits 2:1 and all other bits 0.
- R5: If 3 bytes are short, the pad is 0x07, 0x00, 0x00.
- R6: If 1 byte is short, the R4 pad is appended and then the R5 pad (5 bytes), so the stream ends aligned.
- R7: Stream byte k is carried in word k/4, on bits 8*(k%4)+7 down to 8*(k%4).
- R8: `word_count` equals the stream byte count divided by 4 (1 to 4). It is valid with the first word and stays constant while words are offered.
- R9: While `word_valid` is high and `word_ready` is low, `word_data` holds. Each accepted word advances to the next one.
- R10: `busy` rises the cycle after `start` is sampled in IDLE. It falls right after the last word is accepted. A `start` seen while busy is ignored.
- R11: The first word is offered on the second cycle after `start` is sampled. It is not offered on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and build a stream |
| chan_mask | input | 4 | Channels to select; bit n is channel n |
| mode_code | input | 2 | Serial-mode code placed in control bytes |
| freq_vld | input | 1 | Include the frequency record |
| freq_word | input | 32 | Frequency tuning word |
| phase_vld | input | 1 | Include the phase record |
| phase_word | input | 16 | Phase offset word |
| ampl_vld | input | 1 | Include the amplitude record |
| ampl_word | input | 32 | Amplitude control; low 24 bits used |
| busy | output | 1 | Stream being built or sent |
| word_valid | output | 1 | `word_data` is offered |
| word_ready | input | 1 | Consumer accepts the offered word |
| word_data | output | 32 | Packed stream word |
| word_count | output | 3 | Number of words in this stream |

## Verification
The bench uses the default 16-byte buffer. With that size, every combination of the three optional records fits, and all three padding cases are reached. The eight flag combinations produce raw lengths of 2, 5, 6, 7, 9, 10, 11 and 14 bytes. These cover the 2-, 3- and 1-byte shortfalls and final word counts from 1 to 4, including the 16-byte full buffer. Backpressure stalls and a start pulse arriving during a send are applied on top of these cases.

// File: rtl/psp_pkg.sv
`timescale 1ns/1ps
package psp_pkg;
    localparam int CHAN_W   = 4;
    localparam int MODE_W   = 2;
    localparam logic [7:0] ADDR_CTRL  = 8'h00;
    localparam logic [7:0] ADDR_FREQ  = 8'h04;
    localparam logic [7:0] ADDR_PHASE = 8'h05;
    localparam logic [7:0] ADDR_AMPL  = 8'h06;
    localparam logic [7:0] ADDR_SWEEP = 8'h07;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PACK = 2'd1,
        ST_SEND = 2'd2
    } psp_state_e;

    // channel-select byte: enables in the top nibble, mode in bits 2:1
    function automatic logic [7:0] ctrl_byte(input logic [CHAN_W-1:0] mask,
                                             input logic [MODE_W-1:0] mode);
        return {mask, 1'b0, mode, 1'b0};
    endfunction
endpackage

// File: rtl/psp_assembler.sv
`timescale 1ns/1ps
module psp_assembler
    import psp_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
    input  logic [CHAN_W-1:0]      chan_mask,
    input  logic [MODE_W-1:0]      mode_code,
    input  logic                   freq_vld,
    input  logic [31:0]            freq_word,
    input  logic                   phase_vld,
    input  logic [15:0]            phase_word,
    input  logic                   ampl_vld,
    input  logic [31:0]            ampl_word,
    output logic [8*BUF_BYTES-1:0] stream,
    output logic [CNT_W-1:0]       total_bytes
);
    int wr_ptr;
    int short_by;

    always_comb begin
        stream = '0;
        wr_ptr = 0;
        stream[8*wr_ptr +: 8] = ADDR_CTRL;                     wr_ptr = wr_ptr + 1;
        stream[8*wr_ptr +: 8] = ctrl_byte(chan_mask, mode_code); wr_ptr = wr_ptr + 1;
        if (freq_vld) begin
            stream[8*wr_ptr +: 8] = ADDR_FREQ;          wr_ptr = wr_ptr + 1;
            for (int i = 3; i >= 0; i--) begin
                stream[8*wr_ptr +: 8] = freq_word[8*i +: 8];
                wr_ptr = wr_ptr + 1;
            end
        end
        if (phase_vld) begin
            stream[8*wr_ptr +: 8] = ADDR_PHASE;         wr_ptr = wr_ptr + 1;
            for (int i = 1; i >= 0; i--) begin
                stream[8*wr_ptr +: 8] = phase_word[8*i +: 8];
                wr_ptr = wr_ptr + 1;
            end
        end
        if (ampl_vld) begin
            stream[8*wr_ptr +: 8] = ADDR_AMPL;          wr_ptr = wr_ptr + 1;
            for (int i = 2; i >= 0; i--) begin
                stream[8*wr_ptr +: 8] = ampl_word[8*i +: 8];
                wr_ptr = wr_ptr + 1;
            end
        end
        short_by = (4 - (wr_ptr % 4)) % 4;
        // a 1-byte shortfall uses both pads: 2 + 3 bytes
        if (short_by == 2 || short_by == 1) begin
            stream[8*wr_ptr +: 8] = ADDR_CTRL;                         wr_ptr = wr_ptr + 1;
            stream[8*wr_ptr +: 8] = ctrl_byte('0, mode_code);          wr_ptr = wr_ptr + 1;
        end
        if (short_by == 3 || short_by == 1) begin
            stream[8*wr_ptr +: 8] = ADDR_SWEEP;         wr_ptr = wr_ptr + 1;
            stream[8*wr_ptr +: 8] = 8'h00;              wr_ptr = wr_ptr + 1;
            stream[8*wr_ptr +: 8] = 8'h00;              wr_ptr = wr_ptr + 1;
        end
        total_bytes = CNT_W'(wr_ptr);
    end

    // R6
    always_comb begin
        stream_aligned_chk: assert (total_bytes[1:0] == 2'b00 && total_bytes <= CNT_W'(BUF_BYTES));
    end
endmodule

// File: rtl/psp_word_sel.sv
`timescale 1ns/1ps
module psp_word_sel #(
    parameter int BUF_BYTES = 16,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic [8*BUF_BYTES-1:0] stream,
    input  logic [IDX_W-1:0]       idx,
    output logic [31:0]            word
);
    logic [31:0] lanes [BUF_WORDS];

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_lane
        assign lanes[w] = stream[32*w +: 32];
    end

    assign word = lanes[idx];
endmodule

// File: rtl/psp_stream_packer.sv
`timescale 1ns/1ps
module psp_stream_packer
    import psp_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int CNT_W = $clog2(BUF_BYTES + 1),
    localparam int WCNT_W = $clog2(BUF_WORDS + 1),
    localparam int IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        chan_mask,
    input  logic [1:0]        mode_code,
    input  logic              freq_vld,
    input  logic [31:0]       freq_word,
    input  logic              phase_vld,
    input  logic [15:0]       phase_word,
    input  logic              ampl_vld,
    input  logic [31:0]       ampl_word,
    output logic              busy,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [31:0]       word_data,
    output logic [WCNT_W-1:0] word_count
);
    psp_state_e state_q, state_d;

    logic [CHAN_W-1:0]      mask_q;
    logic [MODE_W-1:0]      mode_q;
    logic                   fv_q, pv_q, av_q;
    logic [31:0]            freq_q, ampl_q;
    logic [15:0]            phase_q;
    logic [8*BUF_BYTES-1:0] stream_q, asm_stream;
    logic [CNT_W-1:0]       asm_total;
    logic [WCNT_W-1:0]      count_q;
    logic [IDX_W-1:0]       idx_q;
    logic                   last_word;

    psp_assembler #(.BUF_BYTES(BUF_BYTES)) u_asm (
        .chan_mask  (mask_q),
        .mode_code  (mode_q),
        .freq_vld   (fv_q),
        .freq_word  (freq_q),
        .phase_vld  (pv_q),
        .phase_word (phase_q),
        .ampl_vld   (av_q),
        .ampl_word  (ampl_q),
        .stream     (asm_stream),
        .total_bytes(asm_total)
    );

    psp_word_sel #(.BUF_BYTES(BUF_BYTES)) u_sel (
        .stream(stream_q),
        .idx   (idx_q),
        .word  (word_data)
    );

    assign last_word = (WCNT_W'(idx_q) == count_q - WCNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PACK;
            ST_PACK: state_d = ST_SEND;
            ST_SEND: if (word_ready && last_word) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        word_valid = (state_q == ST_SEND);
        word_count = count_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            mode_q   <= '0;
            fv_q     <= 1'b0;
            pv_q     <= 1'b0;
            av_q     <= 1'b0;
            freq_q   <= '0;
            phase_q  <= '0;
            ampl_q   <= '0;
            stream_q <= '0;
            count_q  <= '0;
            idx_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    mask_q  <= chan_mask;
                    mode_q  <= mode_code;
                    fv_q    <= freq_vld;
                    pv_q    <= phase_vld;
                    av_q    <= ampl_vld;
                    freq_q  <= freq_word;
                    phase_q <= phase_word;
                    ampl_q  <= ampl_word;
                end
                ST_PACK: begin
                    stream_q <= asm_stream;
                    count_q  <= WCNT_W'(asm_total >> 2);
                    idx_q    <= '0;
                end
                ST_SEND: if (word_ready && !last_word) idx_q <= idx_q + IDX_W'(1);
                default: ;
            endcase
        end
    end

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !word_ready |=> word_valid && $stable(word_data));

    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(word_valid && word_ready));

    // R11
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !word_valid ##1 word_valid);

    // R8
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_count >= WCNT_W'(1)) && (word_count <= WCNT_W'(BUF_WORDS)));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && $past(word_valid) |-> $stable(word_count));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !word_valid);
endmodule

// File: tb/test_psp_stream_packer.sv
`timescale 1ns/1ps
module test_psp_stream_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  chan_mask = '0;
    logic [1:0]  mode_code = '0;
    logic        freq_vld = 1'b0, phase_vld = 1'b0, ampl_vld = 1'b0;
    logic [31:0] freq_word = '0, ampl_word = '0;
    logic [15:0] phase_word = '0;
    logic        busy, word_valid;
    logic        word_ready = 1'b0;
    logic [31:0] word_data;
    logic [2:0]  word_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psp_stream_packer i_psp_stream_packer (
        .clk, .rst_n, .start, .chan_mask, .mode_code,
        .freq_vld, .freq_word, .phase_vld, .phase_word,
        .ampl_vld, .ampl_word, .busy, .word_valid, .word_ready,
        .word_data, .word_count
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected stream built from the requirement text
    logic [7:0]  eb [16];
    int          en;

    task automatic push(input logic [7:0] b);
        eb[en] = b;
        en++;
    endtask

    task automatic build(input logic [3:0] m, input logic [1:0] md,
                         input bit fv, input logic [31:0] f,
                         input bit pv, input logic [15:0] p,
                         input bit av, input logic [31:0] a);
        en = 0;
        push(8'h00); push({m, 1'b0, md, 1'b0});                      // R2
        if (fv) begin push(8'h04); push(f[31:24]); push(f[23:16]); push(f[15:8]); push(f[7:0]); end
        if (pv) begin push(8'h05); push(p[15:8]); push(p[7:0]); end  // R3
        if (av) begin push(8'h06); push(a[23:16]); push(a[15:8]); push(a[7:0]); end
        if (en % 4 == 2 || en % 4 == 3) begin push(8'h00); push({5'b0, md, 1'b0}); end // R4 / R6
        if (en % 4 == 1) begin push(8'h07); push(8'h00); push(8'h00); end              // R5 / R6
    endtask

    task automatic run_case(input string req, input logic [3:0] m, input logic [1:0] md,
                            input bit fv, input logic [31:0] f,
                            input bit pv, input logic [15:0] p,
                            input bit av, input logic [31:0] a,
                            input bit stall, input bit poke);
        build(m, md, fv, f, pv, p, av, a);
        @(negedge clk);
        chan_mask = m; mode_code = md;
        freq_vld = fv; freq_word = f; phase_vld = pv; phase_word = p;
        ampl_vld = av; ampl_word = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R10 busy rise"}, {31'b0, busy}, 32'd1);
        check({req, " R11 no word yet"}, {31'b0, word_valid}, 32'd0);
        @(negedge clk);
        check({req, " R11 first word"}, {31'b0, word_valid}, 32'd1);
        check({req, " R8 count"}, {29'b0, word_count}, 32'(en / 4));
        for (int w = 0; w < en / 4; w++) begin
            logic [31:0] ew;
            ew = {eb[4*w+3], eb[4*w+2], eb[4*w+1], eb[4*w]};          // R7
            if (stall) begin
                word_ready = 1'b0;
                if (poke && w == 0) begin
                    chan_mask = ~m; freq_vld = ~fv; start = 1'b1;
                end
                @(negedge clk);
                start = 1'b0;
                check({req, " R9 held"}, word_data, ew);
                check({req, " R9 valid held"}, {31'b0, word_valid}, 32'd1);
                check({req, " R8 count held"}, {29'b0, word_count}, 32'(en / 4));
            end
            check({req, " R7 word"}, word_data, ew);
            word_ready = 1'b1;
            @(negedge clk);
            word_ready = 1'b0;
        end
        check({req, " R10 busy fall"}, {31'b0, busy}, 32'd0);
        check({req, " R10 idle"}, {31'b0, word_valid}, 32'd0);
        @(negedge clk);
        check({req, " R10 stays idle"}, {31'b0, busy}, 32'd0);
    endtask

    task automatic test_reset();
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 valid", {31'b0, word_valid}, 32'd0);
    endtask

    task automatic test_ctrl_only();       // 2 bytes -> R4 pad, 1 word
        run_case("R2 R4 ctrl", 4'b1010, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic test_freq_only();       // 7 bytes -> R6 pad, 3 words
        run_case("R3 R6 freq", 4'b0001, 2'b10, 1, 32'h1234_5678, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic test_phase_only();      // 5 bytes -> R5 pad, 2 words
        run_case("R3 R5 phase", 4'b0100, 2'b01, 0, 0, 1, 16'h3A5C, 0, 0, 0, 0);
    endtask
    task automatic test_ampl_only();       // 6 bytes -> R4 pad, 2 words
        run_case("R3 R4 ampl", 4'b1000, 2'b00, 0, 0, 0, 0, 1, 32'hFF13_27AB, 0, 0);
    endtask
    task automatic test_freq_phase();      // 10 bytes -> R4 pad
        run_case("R3 freq+phase", 4'b0011, 2'b11, 1, 32'hDEAD_BEEF, 1, 16'h0102, 0, 0, 1, 0);
    endtask
    task automatic test_freq_ampl();       // 11 bytes -> R6 pad, 16 bytes
        run_case("R6 freq+ampl", 4'b1100, 2'b01, 1, 32'hA1B2_C3D4, 0, 0, 1, 32'h0000_13FF, 0, 0);
    endtask
    task automatic test_phase_ampl();      // 9 bytes -> R5 pad
        run_case("R5 phase+ampl", 4'b0110, 2'b10, 0, 0, 1, 16'hFFFF, 1, 32'h00AB_CDEF, 0, 0);
    endtask
    task automatic test_all_fields();      // 14 bytes -> R4 pad, full buffer
        run_case("R3 R7 all", 4'b1111, 2'b11, 1, 32'h0F1E_2D3C, 1, 16'h4B5A, 1, 32'h9988_7766, 1, 0);
    endtask
    task automatic test_start_ignored();   // start pulse during send
        run_case("R10 ignore start", 4'b0101, 2'b01, 0, 0, 1, 16'h2468, 0, 0, 1, 1);
    endtask

    initial begin
        #1;
        test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_ctrl_only();
        test_freq_only();
        test_phase_only();
        test_ampl_only();
        test_freq_phase();
        test_freq_ampl();
        test_phase_ampl();
        test_all_fields();
        test_start_ignored();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule